// File: doc/BRIEF.md
# Sixteen-Function Signed ALU

This block is a purely combinational arithmetic logic unit. Two operands in two's complement form and a four-bit function selector go in. A result of the same width and a single overflow bit come out. The selector picks one of sixteen fixed operations:

- signed addition and subtraction;
- pass-through and inversion of the first operand;
- six two-input bitwise functions;
- four one-bit shifts;
- negation;
- a constant zero.

The overflow bit reports only a wrong signed sum or difference. It stays low for every other function.

The block sits in a datapath between operand registers and a result register. It holds no state, so the result follows the inputs within the same cycle. The operand width is a parameter with a default of 16. A second parameter chooses how the carry path of the shared adder is built.

Top module: `opcode_alu`

## Requirements
- R1: Selector 4'b0000 gives the sum of the operands, wrapped to the operand width.
- R2: Selector 4'b0001 gives the first operand minus the second, wrapped to the operand width.
- R3: Under selector 4'b0000 the overflow bit is 1 exactly when both operands share a sign and the result's sign differs from it.
- R4: Under selector 4'b0001 the overflow bit is 1 exactly when the operand signs differ and the result's sign differs from the first operand's sign.
- R5: For every selector other than 4'b0000 and 4'b0001 the overflow bit is 0.
- R6: Selector 4'b0010 passes the first operand unchanged, and selector 4'b0011 gives its bitwise inverse.
- R7: Selectors 4'b0100, 4'b0101, 4'b0110 and 4'b0111 give bitwise AND, OR, NAND and NOR of the operands.
- R8: Selectors 4'b1000 and 4'b1001 give bitwise XOR and XNOR of the operands.
- R9: Selectors 4'b1010 and 4'b1100 both shift the first operand left by one. Bit 0 becomes 0 and the top bit is dropped.
- R10: Selector 4'b1011 shifts the first operand right by one and fills the top bit with 0.
- R11: Selector 4'b1101 shifts the first operand right by one and copies the old top bit into the top bit.
- R12: Selector 4'b1110 gives the two's complement negation of the first operand. The most negative value maps to itself, with overflow 0.
- R13: Selector 4'b1111 gives all zeros, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand, two's complement |
| opnd_b | input | WIDTH | Second operand, two's complement |
| func_sel | input | 4 | Operation selector |
| result | output | WIDTH | Operation result |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The hardest cases to reach are the edges of the overflow rule. Near the extreme values of the operand range, one step decides between a correct result and a wrapped one. The negation of the most negative value also passes through the shared adder. That adder overflows internally, and the flag must still stay low.

Directed tasks place the operands on each side of these boundaries, for example 0x7FFF plus 1 against 0x7FFE plus 1, and 0x8000 minus 1 against 0x8001 minus 1. A pseudo-random sweep then covers every selector, with the expected values computed from wide integer arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int unsigned SEL_W = 4;

   typedef enum logic [SEL_W-1:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_PASS = 4'd2,
      OP_INV  = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_NAND = 4'd6,
      OP_NOR  = 4'd7,
      OP_XOR  = 4'd8,
      OP_XNOR = 4'd9,
      OP_SHL  = 4'd10,
      OP_SHR  = 4'd11,
      OP_SAL  = 4'd12,
      OP_SAR  = 4'd13,
      OP_NEG  = 4'd14,
      OP_ZERO = 4'd15
   } alu_op_e;

   function automatic logic uses_adder(alu_op_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG);
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int unsigned WIDTH       = 16,
   parameter int unsigned CARRY_CHAIN = 0
) (
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   input  logic             do_sub,
   output logic [WIDTH-1:0] sum,
   output logic             sgn_ovf
);

   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] rhs_eff;

   assign rhs_eff = rhs ^ {WIDTH{do_sub}};

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_addsub: WIDTH must be at least 2");
   end

   if (CARRY_CHAIN > 1) begin : g_bad_chain
      $error("alu_addsub: CARRY_CHAIN must be 0 or 1");
   end

   if (CARRY_CHAIN == 1) begin : g_ripple
      // Explicit bit-serial carry chain; overflow from the last two carries.
      always_comb begin
         logic carry;
         logic carry_prev;
         carry      = do_sub;
         carry_prev = do_sub;
         sum        = '0;
         for (int i = 0; i < WIDTH; i++) begin
            sum[i]     = lhs[i] ^ rhs_eff[i] ^ carry;
            carry_prev = carry;
            carry      = (lhs[i] & rhs_eff[i]) | (carry & (lhs[i] ^ rhs_eff[i]));
         end
         sgn_ovf = carry ^ carry_prev;
      end
   end else begin : g_behav
      // Single wide add left to the synthesis tool; overflow from sign bits.
      assign sum     = lhs + rhs_eff + {{(WIDTH-1){1'b0}}, do_sub};
      assign sgn_ovf = (lhs[MSB] == rhs_eff[MSB]) && (sum[MSB] != lhs[MSB]);
   end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   input  alu_op_e          op,
   output logic [WIDTH-1:0] res
);

   logic [WIDTH-1:0] conj;
   logic [WIDTH-1:0] disj;
   logic [WIDTH-1:0] diff;

   assign conj = lhs & rhs;
   assign disj = lhs | rhs;
   assign diff = lhs ^ rhs;

   always_comb begin
      unique case (op)
         OP_PASS: res = lhs;
         OP_INV:  res = ~lhs;
         OP_AND:  res = conj;
         OP_OR:   res = disj;
         OP_NAND: res = ~conj;
         OP_NOR:  res = ~disj;
         OP_XOR:  res = diff;
         OP_XNOR: res = ~diff;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
   import alu_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] src,
   input  alu_op_e          op,
   output logic [WIDTH-1:0] res
);

   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] up;
   logic [WIDTH-1:0] down;
   logic             fill;

   // Left shifts share one path: both fill bit 0 with zero.
   assign up   = {src[MSB-1:0], 1'b0};
   assign fill = (op == OP_SAR) ? src[MSB] : 1'b0;
   assign down = {fill, src[MSB:1]};

   always_comb begin
      unique case (op)
         OP_SHL, OP_SAL: res = up;
         OP_SHR, OP_SAR: res = down;
         default:        res = '0;
      endcase
   end

endmodule

// File: rtl/opcode_alu.sv
module opcode_alu
   import alu_pkg::*;
#(
   parameter int unsigned WIDTH       = 16,
   parameter int unsigned CARRY_CHAIN = 0
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [3:0]       func_sel,
   output logic [WIDTH-1:0] result,
   output logic             ovf
);

   alu_op_e          op;
   logic [WIDTH-1:0] add_l;
   logic [WIDTH-1:0] add_r;
   logic             add_sub;
   logic [WIDTH-1:0] add_res;
   logic             add_ovf;
   logic [WIDTH-1:0] lgc_res;
   logic [WIDTH-1:0] shf_res;

   if (WIDTH < 2) begin : g_bad_width
      $error("opcode_alu: WIDTH must be at least 2");
   end

   assign op = alu_op_e'(func_sel);

   // Negation reuses the adder as 0 - A.
   assign add_l   = (op == OP_NEG) ? '0 : opnd_a;
   assign add_r   = (op == OP_NEG) ? opnd_a : opnd_b;
   assign add_sub = (op == OP_SUB) || (op == OP_NEG);

   alu_addsub #(.WIDTH(WIDTH), .CARRY_CHAIN(CARRY_CHAIN)) u_addsub (
      .lhs     (add_l),
      .rhs     (add_r),
      .do_sub  (add_sub),
      .sum     (add_res),
      .sgn_ovf (add_ovf)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .lhs (opnd_a),
      .rhs (opnd_b),
      .op  (op),
      .res (lgc_res)
   );

   alu_shift #(.WIDTH(WIDTH)) u_shift (
      .src (opnd_a),
      .op  (op),
      .res (shf_res)
   );

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB, OP_NEG:         result = add_res;
         OP_SHL, OP_SHR, OP_SAL, OP_SAR: result = shf_res;
         OP_ZERO:                        result = '0;
         default:                        result = lgc_res;
      endcase
   end

   // Negation goes through the adder but never reports overflow.
   assign ovf = add_ovf && ((op == OP_ADD) || (op == OP_SUB));

endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic [3:0]       func_sel,
   input logic [WIDTH-1:0] result,
   input logic             ovf
);

   localparam int unsigned MSB = WIDTH - 1;

   logic known;
   assign known = !$isunknown({opnd_a, opnd_b, func_sel, result, ovf});

   always_comb begin
      if (known) begin
         assert_no_overflow_R5: assert (!ovf || func_sel == 4'd0 || func_sel == 4'd1)
            else $error("overflow raised outside add/sub");
         assert_add_ovf_R3: assert (func_sel != 4'd0 ||
            ovf == ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])))
            else $error("add overflow rule broken");
         assert_sub_ovf_R4: assert (func_sel != 4'd1 ||
            ovf == ((opnd_a[MSB] != opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])))
            else $error("sub overflow rule broken");
         assert_shl_fill_R9: assert (!(func_sel == 4'd10 || func_sel == 4'd12) ||
            (result[0] == 1'b0 && result[MSB:1] == opnd_a[MSB-1:0]))
            else $error("left shift wrong");
         assert_lsr_fill_R10: assert (func_sel != 4'd11 ||
            (result[MSB] == 1'b0 && result[MSB-1:0] == opnd_a[MSB:1]))
            else $error("logical right shift wrong");
         assert_asr_fill_R11: assert (func_sel != 4'd13 ||
            (result[MSB] == opnd_a[MSB] && result[MSB-1:0] == opnd_a[MSB:1]))
            else $error("arithmetic right shift wrong");
         assert_neg_sum_R12: assert (func_sel != 4'd14 || (result + opnd_a) == '0)
            else $error("negation wrong");
         assert_zero_code_R13: assert (func_sel != 4'd15 || result == '0)
            else $error("zero code gave nonzero");
      end
   end

endmodule

bind opcode_alu alu_chk #(.WIDTH(WIDTH)) u_alu_chk (
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b),
   .func_sel (func_sel),
   .result   (result),
   .ovf      (ovf)
);

// File: tb/tb_opcode_alu.sv
module tb_opcode_alu;

   localparam int W = 16;

   logic         clk;
   logic [W-1:0] opnd_a;
   logic [W-1:0] opnd_b;
   logic [3:0]   func_sel;
   logic [W-1:0] result;
   logic         ovf;

   int  n_vec  = 0;
   int  n_bad  = 0;
   bit  done   = 0;
   logic [31:0] rng = 32'h1234_5678;

   opcode_alu #(.WIDTH(W)) dut (
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .func_sel (func_sel),
      .result   (result),
      .ovf      (ovf)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   function automatic string tag_of(logic [3:0] c);
      case (c)
         4'd0: return "R1";
         4'd1: return "R2";
         4'd2, 4'd3: return "R6";
         4'd4, 4'd5, 4'd6, 4'd7: return "R7";
         4'd8, 4'd9: return "R8";
         4'd10, 4'd12: return "R9";
         4'd11: return "R10";
         4'd13: return "R11";
         4'd14: return "R12";
         default: return "R13";
      endcase
   endfunction

   function automatic logic [W-1:0] exp_res(logic [3:0] c, logic [W-1:0] a, logic [W-1:0] b);
      int sa, sb;
      sa = int'($signed(a));
      sb = int'($signed(b));
      case (c)
         4'd0:  return W'(sa + sb);
         4'd1:  return W'(sa - sb);
         4'd2:  return a;
         4'd3:  return ~a;
         4'd4:  return a & b;
         4'd5:  return a | b;
         4'd6:  return ~(a & b);
         4'd7:  return ~(a | b);
         4'd8:  return a ^ b;
         4'd9:  return ~(a ^ b);
         4'd10, 4'd12: return W'(sa * 2);
         4'd11: return W'(int'(a) / 2);
         4'd13: return W'(sa >>> 1);
         4'd14: return W'(-sa);
         default: return '0;
      endcase
   endfunction

   function automatic logic exp_ovf(logic [3:0] c, logic [W-1:0] a, logic [W-1:0] b);
      int r;
      if (c == 4'd0)      r = int'($signed(a)) + int'($signed(b));
      else if (c == 4'd1) r = int'($signed(a)) - int'($signed(b));
      else return 1'b0;
      return (r > 32767) || (r < -32768);
   endfunction

   task automatic apply(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] er;
      logic         eo;
      string        ot;
      @(posedge clk);
      #1;
      func_sel = c;
      opnd_a   = a;
      opnd_b   = b;
      @(negedge clk);
      er = exp_res(c, a, b);
      eo = exp_ovf(c, a, b);
      ot = (c == 4'd0) ? "R3" : (c == 4'd1) ? "R4" : "R5";
      n_vec++;
      if (result !== er || ovf !== eo) begin
         n_bad++;
         if (result !== er)
            $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h",
                     tag_of(c), c, a, b, result, er);
         if (ovf !== eo)
            $display("FAIL %s op=%0d a=%h b=%h ovf actual=%b expected=%b",
                     ot, c, a, b, ovf, eo);
      end
   endtask

   task automatic t_idle();
      // all-zero inputs: add of zeros gives 0, no overflow (R1, R3)
      apply(4'd0, '0, '0);
   endtask

   task automatic t_add();
      apply(4'd0, 16'd100, 16'd23);       // R1
      apply(4'd0, 16'hFFFF, 16'h0001);    // R1 wrap to 0, no ovf (R3)
      apply(4'd0, 16'h7FFF, 16'h0001);    // R3 positive overflow
      apply(4'd0, 16'h7FFE, 16'h0001);    // R3 just below edge
      apply(4'd0, 16'h8000, 16'hFFFF);    // R3 negative overflow
      apply(4'd0, 16'h8000, 16'h8000);    // R3
      apply(4'd0, 16'h7FFF, 16'h8000);    // R3 mixed signs never overflow
   endtask

   task automatic t_sub();
      apply(4'd1, 16'd50, 16'd75);        // R2
      apply(4'd1, 16'h8000, 16'h0001);    // R4 overflow
      apply(4'd1, 16'h8001, 16'h0001);    // R4 edge, no overflow
      apply(4'd1, 16'h7FFF, 16'hFFFF);    // R4 overflow
      apply(4'd1, 16'h0000, 16'h8000);    // R4 overflow
      apply(4'd1, 16'hFFFF, 16'h8000);    // R4 no overflow
      apply(4'd1, 16'h1234, 16'h1234);    // R2 zero
   endtask

   task automatic t_logic();
      for (int c = 2; c <= 9; c++) begin
         apply(4'(c), 16'hA5C3, 16'h0FF0);   // R6 R7 R8
         apply(4'(c), 16'hFFFF, 16'h0000);
      end
   endtask

   task automatic t_shift();
      apply(4'd10, 16'hC001, 16'h0);      // R9
      apply(4'd12, 16'hC001, 16'h0);      // R9 same as logical
      apply(4'd11, 16'h8002, 16'h0);      // R10 top fill 0
      apply(4'd13, 16'h8002, 16'h0);      // R11 top fill 1
      apply(4'd13, 16'h4002, 16'h0);      // R11 top fill 0
      apply(4'd12, 16'h7FFF, 16'h7FFF);   // R5 shift no ovf
   endtask

   task automatic t_neg_zero();
      apply(4'd14, 16'h0001, 16'h0);      // R12
      apply(4'd14, 16'h8000, 16'h0);      // R12 most negative, ovf 0 (R5)
      apply(4'd14, 16'h0000, 16'h0);      // R12
      apply(4'd15, 16'hFFFF, 16'hFFFF);   // R13
      apply(4'd15, 16'h8000, 16'h7FFF);   // R13
   endtask

   task automatic t_sweep();
      for (int c = 0; c < 16; c++) begin
         for (int k = 0; k < 64; k++) begin
            logic [W-1:0] a, b;
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            a = rng[31:16];
            b = rng[15:0];
            apply(4'(c), a, b);
         end
      end
   endtask

   initial begin
      func_sel = 4'd0;
      opnd_a   = '0;
      opnd_b   = '0;
      t_idle();
      t_add();
      t_sub();
      t_logic();
      t_shift();
      t_neg_zero();
      t_sweep();
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule